// File: doc/BRIEF.md
# Mailbox Transmit Register Block

This block is the sending half of a mailbox between processor cores. A local processor reaches it through a small 32-bit register port. To post a message, software loads two 32-bit words and a destination number from 0 to 7, then writes 1 to a launch register. The block copies the 64-bit message into a holding slot for that destination and offers it on that destination's valid/ready handshake. Each destination has its own slot, so all eight can hold a message at the same time.

Per-destination status is packed into one read-only word: an 8-bit busy field (message offered but not yet taken), an 8-bit overflow field (a launch arrived while the slot was still busy, and that message was discarded) and an 8-bit delivered field (the remote side took a message). Software clears delivered and overflow flags by writing ones to those positions in a separate clear register. A write-one-to-mask register selects which of three events (launch blocked, new overflow, delivery) set the latched interrupt. A pending interrupt stays set until software writes 1 to bit 0 of the interrupt register.

Top module: `mbox_tx_top`

## Requirements
- R1: After reset the mask register (0x1C) reads 7, the status register (0x14) and the interrupt register (0x18) read 0, no `txValid` bit is high and `irqOut` is low.
- R2: Registers 0x00 (destination number, bits [2:0]), 0x04 (low word), 0x08 (high word) and 0x1C (mask, bits [2:0]) read back what was last written. The launch register 0x0C and the clear register 0x10 always read 0.
- R3: Writing a value with bit 0 = 1 to 0x0C while destination k (the value in 0x00) is not busy raises `txValid[k]` on the next cycle. The slot `txMsg[64k+63:64k]` then holds {high word, low word}. A write to 0x0C with bit 0 = 0 launches nothing.
- R4: While `txValid[k]` is high and `txReady[k]` is low, `txValid[k]` and the slot contents hold. Status bit k (busy) equals `txValid[k]`. The cycle after `txValid[k]` and `txReady[k]` are both high, `txValid[k]` is low.
- R5: A completed handshake on destination k sets status bit 16+k (delivered).
- R6: A launch toward a destination that is still busy sets status bit 8+k (overflow). The new message is discarded and the slot keeps the earlier message. A launch in the same cycle as that slot's handshake counts as busy.
- R7: Writing to 0x10 clears exactly the delivered bits given by ones in [23:16] and the overflow bits given by ones in [15:8]. Other flags and the busy bits do not change.
- R8: Mask bit 0 gates the blocked event (any launch toward a busy destination), bit 1 gates the overflow event (a launch that sets an overflow flag that was clear), and bit 2 gates the delivered event (any handshake). A mask bit of 1 suppresses its event. An unmasked event sets interrupt register bit 0, which drives `irqOut`, at the same clock edge.
- R9: The pending interrupt stays set until 1 is written to bit 0 of 0x18. An unmasked event in the same cycle as that write leaves it set. Writing 0 there does nothing.
- R10: Destinations are independent: several can be busy at once, each with its own slot and its own handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 6 | Byte offset of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| txValid | output | 8 | Per-destination message offered (busy) |
| txReady | input | 8 | Per-destination message taken |
| txMsg | output | 512 | Per-destination 64-bit slots, destination k at bits [64k+63:64k] |
| irqOut | output | 1 | Latched interrupt request |

## Verification
The bench builds the block with its defaults: eight destinations and 32-bit words. This is the only build in which the status fields fill all eight bits and the top destination numbers (5, 6, 7) exist, so clear-register bit positions and overflow bit 14 can be checked at their real places. With 32-bit words, the two halves of each 64-bit slot can be told apart, which catches a swapped word order. The three mask bits are driven one at a time so each interrupt source is seen alone, including the case where overflow repeats on a flag that is already set.

// File: rtl/mbox_tx_pkg.sv
package mbox_tx_pkg;

  localparam int FIELD_W = 8;

  localparam logic [5:0] OFF_TGT   = 6'h00;
  localparam logic [5:0] OFF_LO    = 6'h04;
  localparam logic [5:0] OFF_HI    = 6'h08;
  localparam logic [5:0] OFF_FIRE  = 6'h0C;
  localparam logic [5:0] OFF_CLR   = 6'h10;
  localparam logic [5:0] OFF_STS   = 6'h14;
  localparam logic [5:0] OFF_IRQ   = 6'h18;
  localparam logic [5:0] OFF_MASK  = 6'h1C;

  // strobes from control to datapath
  typedef struct packed {
    logic wrTgt;
    logic wrLo;
    logic wrHi;
    logic fire;
    logic clrFlags;
    logic clrIrq;
    logic wrMask;
  } mboxStrobe_t;

  typedef enum logic [2:0] {
    RD_TGT, RD_LO, RD_HI, RD_STS, RD_IRQ, RD_MASK, RD_ZERO
  } rdSel_t;

endpackage

// File: rtl/mbox_tx_ctrl.sv
module mbox_tx_ctrl
  import mbox_tx_pkg::*;
(
  input  logic        regWrEn,
  input  logic [5:0]  regAddr,
  input  logic        wrBit0,
  output mboxStrobe_t strb,
  output rdSel_t      rdSel
);

  always_comb begin
    strb          = '0;
    strb.wrTgt    = regWrEn && (regAddr == OFF_TGT);
    strb.wrLo     = regWrEn && (regAddr == OFF_LO);
    strb.wrHi     = regWrEn && (regAddr == OFF_HI);
    strb.fire     = regWrEn && (regAddr == OFF_FIRE) && wrBit0;
    strb.clrFlags = regWrEn && (regAddr == OFF_CLR);
    strb.clrIrq   = regWrEn && (regAddr == OFF_IRQ) && wrBit0;
    strb.wrMask   = regWrEn && (regAddr == OFF_MASK);
  end

  always_comb begin
    case (regAddr)
      OFF_TGT:  rdSel = RD_TGT;
      OFF_LO:   rdSel = RD_LO;
      OFF_HI:   rdSel = RD_HI;
      OFF_STS:  rdSel = RD_STS;
      OFF_IRQ:  rdSel = RD_IRQ;
      OFF_MASK: rdSel = RD_MASK;
      default:  rdSel = RD_ZERO;
    endcase
  end

endmodule

// File: rtl/mbox_tx_dp.sv
module mbox_tx_dp
  import mbox_tx_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  mboxStrobe_t               strb,
  input  rdSel_t                    rdSel,
  input  logic [DATA_W-1:0]         regWrData,
  output logic [DATA_W-1:0]         regRdData,
  output logic [NUM_TGT-1:0]        txValid,
  input  logic [NUM_TGT-1:0]        txReady,
  output logic [NUM_TGT*2*DATA_W-1:0] txMsg,
  output logic                      irqOut
);

  localparam int MSG_W = 2 * DATA_W;
  localparam int TGT_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;
  localparam int DLV_LSB = 2 * FIELD_W;
  localparam int OVF_LSB = FIELD_W;

  logic [TGT_W-1:0]   tgtId;
  logic [DATA_W-1:0]  msgLo, msgHi;
  logic [2:0]         maskReg;
  logic               irqPend;
  logic [NUM_TGT-1:0] busy, delivered, overflow;
  logic [NUM_TGT-1:0] fireHit, handshake, newOvf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtId   <= '0;
      msgLo   <= '0;
      msgHi   <= '0;
      maskReg <= 3'b111;
    end else begin
      if (strb.wrTgt)  tgtId   <= regWrData[TGT_W-1:0];
      if (strb.wrLo)   msgLo   <= regWrData;
      if (strb.wrHi)   msgHi   <= regWrData;
      if (strb.wrMask) maskReg <= regWrData[2:0];
    end
  end

  for (genvar k = 0; k < NUM_TGT; k++) begin : g_slot
    logic [MSG_W-1:0] slotMsg;

    assign fireHit[k]   = strb.fire && (tgtId == TGT_W'(k));
    assign handshake[k] = busy[k] && txReady[k];
    assign newOvf[k]    = fireHit[k] && busy[k] && !overflow[k];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busy[k]      <= 1'b0;
        slotMsg      <= '0;
        delivered[k] <= 1'b0;
        overflow[k]  <= 1'b0;
      end else begin
        if (fireHit[k] && !busy[k]) begin
          busy[k] <= 1'b1;
          slotMsg <= {msgHi, msgLo};
        end else if (handshake[k]) begin
          busy[k] <= 1'b0;
        end

        if (handshake[k])
          delivered[k] <= 1'b1;
        else if (strb.clrFlags && regWrData[DLV_LSB+k])
          delivered[k] <= 1'b0;

        if (fireHit[k] && busy[k])
          overflow[k] <= 1'b1;
        else if (strb.clrFlags && regWrData[OVF_LSB+k])
          overflow[k] <= 1'b0;
      end
    end

    assign txMsg[k*MSG_W +: MSG_W] = slotMsg;
  end

  logic evBlocked, evOverflow, evDelivered, irqSet;
  assign evBlocked   = |(fireHit & busy);
  assign evOverflow  = |newOvf;
  assign evDelivered = |handshake;
  assign irqSet = (evBlocked   && !maskReg[0]) ||
                  (evOverflow  && !maskReg[1]) ||
                  (evDelivered && !maskReg[2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            irqPend <= 1'b0;
    else if (irqSet)      irqPend <= 1'b1;
    else if (strb.clrIrq) irqPend <= 1'b0;
  end

  logic [FIELD_W-1:0] busyF, ovfF, dlvF;
  always_comb begin
    busyF = '0;
    ovfF  = '0;
    dlvF  = '0;
    busyF[NUM_TGT-1:0] = busy;
    ovfF[NUM_TGT-1:0]  = overflow;
    dlvF[NUM_TGT-1:0]  = delivered;
  end

  always_comb begin
    regRdData = '0;
    case (rdSel)
      RD_TGT:  regRdData[TGT_W-1:0] = tgtId;
      RD_LO:   regRdData = msgLo;
      RD_HI:   regRdData = msgHi;
      RD_STS:  regRdData[3*FIELD_W-1:0] = {dlvF, ovfF, busyF};
      RD_IRQ:  regRdData[0] = irqPend;
      RD_MASK: regRdData[2:0] = maskReg;
      default: regRdData = '0;
    endcase
  end

  assign txValid = busy;
  assign irqOut  = irqPend;

endmodule

// File: rtl/mbox_tx_top.sv
module mbox_tx_top
  import mbox_tx_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int DATA_W  = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWrEn,
  input  logic [5:0]                  regAddr,
  input  logic [DATA_W-1:0]           regWrData,
  output logic [DATA_W-1:0]           regRdData,
  output logic [NUM_TGT-1:0]          txValid,
  input  logic [NUM_TGT-1:0]          txReady,
  output logic [NUM_TGT*2*DATA_W-1:0] txMsg,
  output logic                        irqOut
);

  mboxStrobe_t strb;
  rdSel_t      rdSel;

  mbox_tx_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .wrBit0  (regWrData[0]),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  mbox_tx_dp #(.NUM_TGT(NUM_TGT), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdSel     (rdSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .txValid   (txValid),
    .txReady   (txReady),
    .txMsg     (txMsg),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/mbox_tx_chk.sv
module mbox_tx_chk #(
  parameter int NUM_TGT = 8,
  parameter int DATA_W  = 32
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        regWrEn,
  input logic [5:0]                  regAddr,
  input logic                        fireBit,
  input logic [NUM_TGT-1:0]          txValid,
  input logic [NUM_TGT-1:0]          txReady,
  input logic [NUM_TGT*2*DATA_W-1:0] txMsg,
  input logic                        irqOut
);

  localparam int MSG_W = 2 * DATA_W;

  logic fireWr, irqClrWr;
  assign fireWr   = regWrEn && (regAddr == 6'h0C) && fireBit;
  assign irqClrWr = regWrEn && (regAddr == 6'h18) && fireBit;

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid & ~txReady) != '0 |=>
      ((txValid & $past(txValid & ~txReady)) == $past(txValid & ~txReady)));

  // R3
  new_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((txValid & ~$past(txValid)) != '0) |-> $past(fireWr));

  // R3
  single_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(txValid & ~$past(txValid)));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !irqClrWr) |=> irqOut);

  for (genvar k = 0; k < NUM_TGT; k++) begin : g_slot_chk
    // R4
    slot_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      (txValid[k] && !txReady[k]) |=>
        (txMsg[k*MSG_W +: MSG_W] == $past(txMsg[k*MSG_W +: MSG_W])));
  end

endmodule

bind mbox_tx_top mbox_tx_chk #(.NUM_TGT(NUM_TGT), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regWrEn (regWrEn),
  .regAddr (regAddr),
  .fireBit (regWrData[0]),
  .txValid (txValid),
  .txReady (txReady),
  .txMsg   (txMsg),
  .irqOut  (irqOut)
);

// File: tb/test_mbox_tx_top.sv
`timescale 1ns/1ps
module test_mbox_tx_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0;
  logic [5:0]   regAddr = '0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic [7:0]   txValid;
  logic [7:0]   txReady = '0;
  logic [511:0] txMsg;
  logic         irqOut;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mbox_tx_top i_mbox_tx_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .txValid(txValid),
    .txReady(txReady), .txMsg(txMsg), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic pulseReady(input logic [7:0] r);
    @(negedge clk);
    txReady = r;
    @(negedge clk);
    txReady = '0;
  endtask

  task automatic post(input logic [2:0] id, input logic [31:0] lo, input logic [31:0] hi);
    busWrite(6'h00, {29'd0, id});
    busWrite(6'h04, lo);
    busWrite(6'h08, hi);
    busWrite(6'h0C, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    busRead(6'h1C, d); chk("R1 mask", d, 7);
    busRead(6'h14, d); chk("R1 status", d, 0);
    busRead(6'h18, d); chk("R1 irq reg", d, 0);
    chk("R1 txValid", txValid, 0);
    chk("R1 irqOut", irqOut, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    busWrite(6'h00, 32'd3);
    busWrite(6'h04, 32'hA1A2A3A4);
    busWrite(6'h08, 32'hB1B2B3B4);
    busRead(6'h00, d); chk("R2 id", d, 3);
    busRead(6'h04, d); chk("R2 low", d, 32'hA1A2A3A4);
    busRead(6'h08, d); chk("R2 high", d, 32'hB1B2B3B4);
    busRead(6'h0C, d); chk("R2 launch reads 0", d, 0);
    busRead(6'h10, d); chk("R2 clear reads 0", d, 0);
  endtask

  task automatic t_send();
    logic [31:0] d;
    busWrite(6'h0C, 32'd0);
    chk("R3 bit0=0 no launch", txValid, 0);
    busWrite(6'h0C, 32'd1);
    chk("R3 valid", txValid, 8'h08);
    chk("R3 slot", txMsg[3*64 +: 64], 64'hB1B2B3B4_A1A2A3A4);
    busRead(6'h14, d); chk("R4 busy bit", d, 32'h08);
    repeat (3) @(negedge clk);
    chk("R4 held", txValid, 8'h08);
    chk("R4 slot held", txMsg[3*64 +: 64], 64'hB1B2B3B4_A1A2A3A4);
    chk("R8 all masked", irqOut, 0);
    pulseReady(8'h08);
    chk("R4 drop after handshake", txValid, 0);
    busRead(6'h14, d); chk("R5 delivered bit 19", d, 32'h0008_0000);
  endtask

  task automatic t_irqDelivered();
    logic [31:0] d;
    busWrite(6'h1C, 32'b011);
    busRead(6'h1C, d); chk("R2 mask readback", d, 3);
    post(3'd5, 32'h5, 32'h50);
    chk("R8 launch no irq", irqOut, 0);
    pulseReady(8'h20);
    chk("R8 delivered irq", irqOut, 1);
    busRead(6'h18, d); chk("R8 irq reg", d, 1);
    busWrite(6'h18, 32'd0);
    chk("R9 write 0 keeps", irqOut, 1);
    busWrite(6'h18, 32'd1);
    chk("R9 cleared", irqOut, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    busWrite(6'h1C, 32'b101);
    post(3'd6, 32'hC0C0C0C0, 32'hD0D0D0D0);
    chk("R8 no irq on launch", irqOut, 0);
    busWrite(6'h04, 32'hEEEEEEEE);
    busWrite(6'h0C, 32'd1);
    busRead(6'h14, d); chk("R6 overflow bit 14", d[15:0], 16'h4040);
    chk("R6 slot kept", txMsg[6*64 +: 64], 64'hD0D0D0D0_C0C0C0C0);
    chk("R8 overflow irq", irqOut, 1);
    busWrite(6'h18, 32'd1);
    busWrite(6'h0C, 32'd1);
    chk("R8 repeat overflow no irq", irqOut, 0);
    busWrite(6'h1C, 32'b110);
    busWrite(6'h0C, 32'd1);
    chk("R8 blocked irq", irqOut, 1);
    busWrite(6'h18, 32'd1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    busRead(6'h14, d); chk("R7 before", d, 32'h0028_4040);
    busWrite(6'h10, 32'h0008_4040);
    busRead(6'h14, d); chk("R7 exact clear", d, 32'h0020_0040);
    chk("R7 busy kept", txValid, 8'h40);
  endtask

  task automatic t_multi();
    logic [31:0] d;
    post(3'd1, 32'h11, 32'h111);
    post(3'd2, 32'h22, 32'h222);
    chk("R10 three busy", txValid, 8'h46);
    chk("R10 slot1", txMsg[1*64 +: 64], {32'h111, 32'h11});
    chk("R10 slot2", txMsg[2*64 +: 64], {32'h222, 32'h22});
    pulseReady(8'h04);
    chk("R10 only slot2 done", txValid, 8'h42);
    pulseReady(8'h42);
    busRead(6'h14, d); chk("R10 delivered", d, 32'h0066_0000);
    chk("R8 delivered masked", irqOut, 0);
  endtask

  task automatic t_race();
    busWrite(6'h1C, 32'b011);
    post(3'd0, 32'h1, 32'h2);
    post(3'd7, 32'h3, 32'h4);
    pulseReady(8'h01);
    chk("R9 pending", irqOut, 1);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 6'h18; regWrData = 32'd1; txReady = 8'h80;
    @(negedge clk);
    regWrEn = 1'b0; txReady = '0;
    chk("R9 event beats clear", irqOut, 1);
    busWrite(6'h18, 32'd1);
    chk("R9 clear after", irqOut, 0);
  endtask

  task automatic t_sameCycle();
    logic [31:0] d;
    post(3'd4, 32'h44, 32'h440);
    busWrite(6'h04, 32'h99);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 6'h0C; regWrData = 32'd1; txReady = 8'h10;
    @(negedge clk);
    regWrEn = 1'b0; txReady = '0;
    chk("R6 launch at handshake dropped", txValid[4], 0);
    busRead(6'h14, d); chk("R6 overflow bit 12", d[12], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_send();
    t_irqDelivered();
    t_overflow();
    t_clear();
    t_multi();
    t_race();
    t_sameCycle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule